// File: doc/BRIEF.md
# Serial-Controlled Dual Audio/Video Routing Controller

This block is a write-only two-wire serial slave. It takes two control bytes in one transfer and turns them into routing controls for two independent output channels. In each channel, one 4-way source select drives both the video switch and the stereo audio switch. Each channel also has a video gain flag and a stereo mode: mute, right-to-both, left-to-both or normal. The bytes also hold four general-purpose open-drain port bits.

The clock and data lines are sampled on the system clock. Each line passes through a two-flop synchronizer and a short glitch filter before its edges are detected. There is no sub-address. After an accepted address byte, the first data byte loads the channel 1 register and the second data byte loads the channel 2 register. One address bit comes from a select pin. The outputs are decoded mux selects, mute and route enables, gain flags and port pull-downs. No analog switching is modelled.

Top module: `avr_route_ctrl`

## Requirements
- R1: The slave acknowledges the address byte 0x90 when `addr_sel_i` is 0, and 0x92 when it is 1. The byte is sent MSB first, the R/W bit is bit 0 and must be 0, and address bit 1 equals the pin. The acknowledge is `sda_pull_o` held high through the ninth clock.
- R2: An address byte that does not match, or that has R/W = 1, is not acknowledged. No later byte in that transfer is acknowledged or changes any output.
- R3: After an accepted address, the first data byte is acknowledged and loads channel 0, and the second is acknowledged and loads channel 1. Outputs change only when a register is loaded.
- R4: Control bits 1:0 select the source as one-hot `src_oh_o[ch]`: value v sets bit v (0 tuner, 1 input 2, 2 input 3, 3 input 4).
- R5: Control bit 3 drives `gain6_o[ch]`: 0 gives unity gain and 1 gives +6 dB.
- R6: Control bits 7:6 set the stereo mode. 00 sets `mute_o`. 01 sets `l_from_r_o` (right input to both outputs). 10 sets `r_from_l_o` (left input to both outputs). 11 clears all three (normal). At most one of the three is ever high.
- R7: Control bits 4 and 5 of the channel c register drive `port_pull_o[2c]` and `port_pull_o[2c+1]`. A 1 pulls the port low and a 0 releases it.
- R8: Reset clears both registers. The outputs then show tuner source, unity gain, mute set and all ports released.
- R9: A STOP or a repeated START inside a byte drops that byte and leaves its register unchanged. A repeated START begins a new address phase.
- R10: Data bytes after the second in one transfer are not acknowledged and change nothing.
- R11: A pulse on SDA lasting one system clock while SCL is high is ignored. It is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled (wired level) |
| addr_sel_i | input | 1 | Address select pin, sets address bit 1 |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| src_oh_o | output | 2x4 | One-hot source select per channel |
| gain6_o | output | 2 | +6 dB video gain per channel |
| mute_o | output | 2 | Both audio outputs of the channel muted |
| l_from_r_o | output | 2 | Left output takes the right input |
| r_from_l_o | output | 2 | Right output takes the left input |
| port_pull_o | output | 4 | 1 pulls the port pin low |

## Verification
A sweep of a little over a hundred transfers sends pairs of data values spread across the whole byte range. Because channel 0 and channel 1 always get different values, a swapped register index or a field read at the wrong bit position shows up at once. Both settings of the address pin are tried with both candidate addresses and with a read-direction byte. This separates a correct match from one that ignores the pin or the R/W bit. Transfers cut short by STOP or a repeated START, an over-long transfer and a one-cycle SDA glitch each check that only complete, acknowledged bytes in positions one and two reach the registers.

// File: rtl/avr_pkg.sv
// Shared types for the routing controller.
// Assumes one control byte per channel with the field layout below.
package avr_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 2;
    localparam int SRC_N  = 4;
    localparam int PORT_PER_CH = 2;

    // Stereo routing mode held in bits 7:6 of a control byte.
    typedef enum logic [1:0] {
        ST_MUTE = 2'b00,
        ST_R2B  = 2'b01,
        ST_L2B  = 2'b10,
        ST_NORM = 2'b11
    } stereo_e;

    // Control byte layout; bit order is fixed by the bus protocol.
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] port;
        logic       gain;
        logic       spare;
        logic [1:0] src;
    } ctrl_t;

    // Receiver phases.
    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_DATA,
        BUS_SKIP
    } bus_st_e;
endpackage

// File: rtl/avr_line_filter.sv
// Two-flop synchronizer followed by a majority-free agreement filter.
// The output moves only after FILT_LEN consecutive equal samples.
// Assumes the bus level is high when idle.
module avr_line_filter #(
    parameter int   FILT_LEN = 3,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Synchronize, record history and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {2{IDLE_LVL}};
            hist_q <= {FILT_LEN{IDLE_LVL}};
            filt_o <= IDLE_LVL;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                filt_o <= 1'b1;
            else if (~|hist_q)
                filt_o <= 1'b0;
        end
    end
endmodule

// File: rtl/avr_i2c_rx.sv
// Write-only serial slave receiver working on filtered SCL/SDA.
// Detects START/STOP and shifts bytes in MSB first. Matches the 7-bit address
// {ADDR_HI, addr_bit_i} with a write direction. Acknowledges up to NUM_REGS
// data bytes and emits a one-cycle write strobe when each
// acknowledged byte's ninth clock ends.
// Assumes inputs are already synchronized and filtered.
module avr_i2c_rx
    import avr_pkg::*;
#(
    parameter int         NUM_REGS = 2,
    parameter logic [5:0] ADDR_HI  = 6'b100100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_bit_i,
    output logic                  sda_pull_o,
    output logic                  wr_stb_o,
    output logic [IDX_W-1:0]      wr_idx_o,
    output logic [BYTE_W-1:0]     wr_data_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CNT_W = $clog2(NUM_REGS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_REGS);
    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

    bus_st_e            state_q;
    logic [3:0]         bit_cnt_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic               ack_phase_q;
    logic [CNT_W-1:0]   byte_cnt_q;
    logic               scl_d, sda_d;
    logic               scl_rise, scl_fall, start_det, stop_det;
    logic               accept;

    // Remember previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    // Decode bus events from the current and previous levels.
    always_comb begin
        scl_rise  = scl_i && !scl_d;
        scl_fall  = !scl_i && scl_d;
        start_det = scl_i && scl_d && sda_d && !sda_i;
        stop_det  = scl_i && scl_d && !sda_d && sda_i;
    end

    // Decide whether the byte just completed deserves an acknowledge.
    always_comb begin
        if (state_q == BUS_ADDR)
            accept = (shreg_q == {ADDR_HI, addr_bit_i, 1'b0});
        else
            accept = (byte_cnt_q < LAST_CNT);
    end

    // Bus protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= BUS_IDLE;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ack_phase_q <= 1'b0;
            byte_cnt_q  <= '0;
            sda_pull_o  <= 1'b0;
            wr_stb_o    <= 1'b0;
            wr_idx_o    <= '0;
            wr_data_o   <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (start_det) begin
                state_q     <= BUS_ADDR;
                bit_cnt_q   <= '0;
                ack_phase_q <= 1'b0;
                byte_cnt_q  <= '0;
                sda_pull_o  <= 1'b0;
            end else if (stop_det) begin
                state_q     <= BUS_IDLE;
                bit_cnt_q   <= '0;
                ack_phase_q <= 1'b0;
                sda_pull_o  <= 1'b0;
            end else if (state_q == BUS_ADDR || state_q == BUS_DATA) begin
                if (scl_rise && !ack_phase_q && bit_cnt_q != BITS_FULL) begin
                    shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (scl_fall) begin
                    if (ack_phase_q) begin
                        ack_phase_q <= 1'b0;
                        sda_pull_o  <= 1'b0;
                        bit_cnt_q   <= '0;
                        if (state_q == BUS_ADDR) begin
                            state_q <= BUS_DATA;
                        end else begin
                            wr_stb_o   <= 1'b1;
                            wr_idx_o   <= byte_cnt_q[IDX_W-1:0];
                            wr_data_o  <= shreg_q;
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end else if (bit_cnt_q == BITS_FULL) begin
                        if (accept) begin
                            ack_phase_q <= 1'b1;
                            sda_pull_o  <= 1'b1;
                        end else begin
                            state_q    <= BUS_SKIP;
                            sda_pull_o <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/avr_chan_decode.sv
// Decodes one channel control byte into switch selects and enables.
// Purely combinational; assumes the byte is held in a register upstream.
module avr_chan_decode
    import avr_pkg::*;
(
    input  ctrl_t                  ctrl_i,
    output logic [SRC_N-1:0]       src_oh_o,
    output logic                   gain6_o,
    output logic                   mute_o,
    output logic                   l_from_r_o,
    output logic                   r_from_l_o,
    output logic [PORT_PER_CH-1:0] port_pull_o
);
    stereo_e mode;
    logic    unused_spare;

    assign unused_spare = ctrl_i.spare;

    // Source select, gain and port pass-through.
    always_comb begin
        src_oh_o    = '0;
        src_oh_o[ctrl_i.src] = 1'b1;
        gain6_o     = ctrl_i.gain;
        port_pull_o = ctrl_i.port;
    end

    // Stereo mode into mute and cross-route enables.
    always_comb begin
        mode       = stereo_e'(ctrl_i.mode);
        mute_o     = 1'b0;
        l_from_r_o = 1'b0;
        r_from_l_o = 1'b0;
        case (mode)
            ST_MUTE: mute_o     = 1'b1;
            ST_R2B:  l_from_r_o = 1'b1;
            ST_L2B:  r_from_l_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/avr_route_ctrl.sv
// Top of the dual routing controller: line filters, serial receiver,
// two channel registers and per-channel decoders.
// Assumes scl_i/sda_i are the wired bus levels, asynchronous to clk.
module avr_route_ctrl
    import avr_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                scl_i,
    input  logic                                sda_i,
    input  logic                                addr_sel_i,
    output logic                                sda_pull_o,
    output logic [NUM_CH-1:0][SRC_N-1:0]        src_oh_o,
    output logic [NUM_CH-1:0]                   gain6_o,
    output logic [NUM_CH-1:0]                   mute_o,
    output logic [NUM_CH-1:0]                   l_from_r_o,
    output logic [NUM_CH-1:0]                   r_from_l_o,
    output logic [NUM_CH*PORT_PER_CH-1:0]       port_pull_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              scl_f, sda_f;
    logic              wr_stb;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    ctrl_t             ctrl_q [NUM_CH];

    avr_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f)
    );
    avr_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f)
    );

    avr_i2c_rx #(.NUM_REGS(NUM_CH), .ADDR_HI(6'b100100)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .scl_i(scl_f), .sda_i(sda_f), .addr_bit_i(addr_sel_i),
        .sda_pull_o(sda_pull_o),
        .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Channel register: cleared by reset, loaded by its write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[ch] <= '0;
            else if (wr_stb && wr_idx == IDX_W'(ch))
                ctrl_q[ch] <= ctrl_t'(wr_data);
        end

        avr_chan_decode u_dec (
            .ctrl_i(ctrl_q[ch]),
            .src_oh_o(src_oh_o[ch]),
            .gain6_o(gain6_o[ch]),
            .mute_o(mute_o[ch]),
            .l_from_r_o(l_from_r_o[ch]),
            .r_from_l_o(r_from_l_o[ch]),
            .port_pull_o(port_pull_o[ch*PORT_PER_CH +: PORT_PER_CH])
        );
    end
endmodule

// File: rtl/avr_route_ctrl_chk.sv
// Assertion checker bound to avr_route_ctrl. Observes ports plus the
// filtered clock and write strobe, which separate logic drives.
module avr_route_ctrl_chk
    import avr_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          scl_f,
    input logic                          wr_stb,
    input logic                          sda_pull_o,
    input logic [NUM_CH-1:0][SRC_N-1:0]  src_oh_o,
    input logic [NUM_CH-1:0]             gain6_o,
    input logic [NUM_CH-1:0]             mute_o,
    input logic [NUM_CH-1:0]             l_from_r_o,
    input logic [NUM_CH-1:0]             r_from_l_o,
    input logic [NUM_CH*PORT_PER_CH-1:0] port_pull_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assert_src_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(src_oh_o[ch]));
        assert_mode_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({mute_o[ch], l_from_r_o[ch], r_from_l_o[ch]}) <= 1);
    end

    // Outputs move only in the cycle after a register write.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> ($stable(src_oh_o) && $stable(gain6_o) && $stable(mute_o)
                            && $stable(l_from_r_o) && $stable(r_from_l_o)
                            && $stable(port_pull_o)));

    // The acknowledge drive never changes while SCL is high.
    assert_ack_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

    // Right after reset the outputs show the cleared registers.
    assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (port_pull_o == '0 && mute_o == '1 && gain6_o == '0
                           && !sda_pull_o));
endmodule

bind avr_route_ctrl avr_route_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .wr_stb(wr_stb),
    .sda_pull_o(sda_pull_o), .src_oh_o(src_oh_o), .gain6_o(gain6_o),
    .mute_o(mute_o), .l_from_r_o(l_from_r_o), .r_from_l_o(r_from_l_o),
    .port_pull_o(port_pull_o)
);

// File: tb/avr_route_ctrl_bench.sv
module avr_route_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_line;
    logic sda_pull;
    logic [1:0][3:0] src_oh;
    logic [1:0] gain6, mute, lfr, rfl;
    logic [3:0] port_pull;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q [2];

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    avr_route_ctrl u_avr_route_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .src_oh_o(src_oh),
        .gain6_o(gain6), .mute_o(mute), .l_from_r_o(lfr), .r_from_l_o(rfl),
        .port_pull_o(port_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Compare every output against the expected register contents.
    task automatic check_outputs(input string ctx);
        for (int c = 0; c < 2; c++) begin
            logic [7:0] d;
            d = exp_q[c];
            chk({ctx, " R4 source"}, int'(src_oh[c]), int'(4'b0001 << d[1:0]));
            chk({ctx, " R5 gain"}, int'(gain6[c]), int'(d[3]));
            chk({ctx, " R6 mode"}, int'({mute[c], lfr[c], rfl[c]}),
                int'({d[7:6] == 2'b00, d[7:6] == 2'b01, d[7:6] == 2'b10}));
            chk({ctx, " R7 ports"}, int'(port_pull[2*c +: 2]), int'(d[5:4]));
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(4*Q);
    endtask

    task automatic send_bit(input logic b, input logic glitch);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        if (glitch) begin
            sda_m = 1'b0; tick(1);
            sda_m = b; tick(Q-1);
        end else begin
            tick(Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic txn(input logic [7:0] adr, input logic [7:0] d1, input logic [7:0] d2,
                       output logic a0, output logic a1, output logic a2);
        bus_start();
        send_byte(adr, 1'b0, a0);
        send_byte(d1, 1'b0, a1);
        send_byte(d2, 1'b0, a2);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic a0, a1, a2, a3;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        exp_q[0] = 8'h00; exp_q[1] = 8'h00;
        chk("R8 ack idle", int'(sda_pull), 0);
        check_outputs("R8 reset");

        // Sweep: distinct values per channel, pin low, address 0x90.
        for (int i = 0; i < 112; i++) begin
            logic [7:0] d1, d2;
            d1 = 8'((i*37 + 5) & 255);
            d2 = 8'((i*91 + 200) & 255);
            txn(8'h90, d1, d2, a0, a1, a2);
            chk("R1 addr ack", int'(a0), 1);
            chk("R3 data1 ack", int'(a1), 1);
            chk("R3 data2 ack", int'(a2), 1);
            exp_q[0] = d1; exp_q[1] = d2;
            check_outputs("R3 sweep");
        end

        // Pin high: 0x92 accepted, 0x90 rejected.
        addr_sel = 1'b1;
        txn(8'h92, 8'hC9, 8'h36, a0, a1, a2);
        chk("R1 pin-high 0x92 ack", int'({a0, a1, a2}), 7);
        exp_q[0] = 8'hC9; exp_q[1] = 8'h36;
        check_outputs("R1 pin-high");
        txn(8'h90, 8'h00, 8'hFF, a0, a1, a2);
        chk("R2 pin-high 0x90 nack", int'({a0, a1, a2}), 0);
        check_outputs("R2 unchanged");

        // Pin low: 0x92 and read direction rejected.
        addr_sel = 1'b0;
        txn(8'h92, 8'h00, 8'hFF, a0, a1, a2);
        chk("R2 pin-low 0x92 nack", int'({a0, a1, a2}), 0);
        txn(8'h91, 8'h00, 8'hFF, a0, a1, a2);
        chk("R2 read nack", int'({a0, a1, a2}), 0);
        check_outputs("R2 unchanged");

        // STOP inside DATA2: channel 0 loads, channel 1 keeps its value.
        bus_start();
        send_byte(8'h90, 1'b0, a0);
        send_byte(8'h7B, 1'b0, a1);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
        bus_stop();
        exp_q[0] = 8'h7B;
        check_outputs("R9 stop abort");

        // Repeated START inside DATA1: byte dropped.
        bus_start();
        send_byte(8'h90, 1'b0, a0);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        bus_start();
        bus_stop();
        check_outputs("R9 restart abort");

        // Repeated START mid-byte, then a full new transfer.
        bus_start();
        send_byte(8'h90, 1'b0, a0);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        bus_start();
        send_byte(8'h90, 1'b0, a0);
        send_byte(8'h4E, 1'b0, a1);
        send_byte(8'hB1, 1'b0, a2);
        bus_stop();
        chk("R9 restart acks", int'({a0, a1, a2}), 7);
        exp_q[0] = 8'h4E; exp_q[1] = 8'hB1;
        check_outputs("R9 restart full");

        // Extra byte after DATA2.
        bus_start();
        send_byte(8'h90, 1'b0, a0);
        send_byte(8'hD2, 1'b0, a1);
        send_byte(8'h2D, 1'b0, a2);
        send_byte(8'h00, 1'b0, a3);
        bus_stop();
        chk("R10 extra nack", int'(a3), 0);
        exp_q[0] = 8'hD2; exp_q[1] = 8'h2D;
        check_outputs("R10 extra ignored");

        // One-cycle SDA glitches during SCL high on every 1 bit.
        bus_start();
        send_byte(8'h90, 1'b1, a0);
        send_byte(8'hB8, 1'b1, a1);
        send_byte(8'h67, 1'b1, a2);
        bus_stop();
        chk("R11 glitch acks", int'({a0, a1, a2}), 7);
        exp_q[0] = 8'hB8; exp_q[1] = 8'h67;
        check_outputs("R11 glitch");

        // Reset again clears everything.
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(2);
        exp_q[0] = 8'h00; exp_q[1] = 8'h00;
        check_outputs("R8 re-reset");

        summary();
        $finish;
    end
endmodule